// File: doc/BRIEF.md
# Two-Level Local History Predictor

This block predicts the direction of conditional branches from each branch's own past behaviour. A group of PC bits picks one of a bank of shift registers, and each register holds the most recent taken/not-taken outcomes of the branches that map to it. The value in that register then selects one entry in a shared table of saturating counters. The upper bit of that counter is the prediction.

The predict side is purely combinational: a fetch address goes in and a direction comes out in the same cycle. The update side takes a resolved branch address and its actual outcome. On the next rising clock edge it adjusts the counter selected by the register's current value, and it shifts the outcome into that register. The register bank and the counter table both clear on an asynchronous active-low reset.

Top module: `local_hist_predictor`

## Requirements
- R1: While reset is held and right after it is released, every history register reads zero and every counter holds weakly not taken (01), so the prediction is not taken for every PC.
- R2: The history register is chosen by PC bits [7:2]. PCs that differ only outside those bits share one register, and bits [1:0] have no effect.
- R3: The counter table is indexed by the 6-bit value of the chosen history register alone, so different registers holding equal values share one counter. The prediction is the counter's upper bit (1 = taken).
- R4: A taken update raises the counter by one, and it stays at 11 once it is there.
- R5: A not-taken update lowers the counter by one, and it stays at 00 once it is there.
- R6: An update first adjusts the counter at the register's value from before the update. The outcome is then shifted into bit 0 of the register (1 = taken) and the oldest bit is dropped, all on one clock edge.
- R7: A counter at 11 still predicts taken after one not-taken update.
- R8: When upd_valid is low, neither the counters nor the history registers change, whatever upd_pc and upd_taken are.
- R9: A loop branch that is taken trip-1 times and then not taken once, with trip count 4 or 6, is predicted correctly on every instance after ten iterations of warm-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | 32 | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Apply a training update this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The hardest case to reach is driving a single counter through saturation and back. Every update also shifts the history, so the next update lands on a different counter. The stimulus works around this in two ways. A branch that is always taken pins its register at all ones, which lets one counter be pushed past 11. After a single not-taken update, six taken updates bring the register back to the same index. A branch that is always not taken keeps its register at zero, so repeated decrements reach the same counter, and neighbouring registers that still hold zero read that counter without moving it.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

   localparam int unsigned CTR_W_MAX = 8;

   typedef logic [CTR_W_MAX-1:0] ctr_word_t;

   // Reset value: weakest state that still predicts not taken
   function automatic ctr_word_t ctr_weak_nt(int unsigned w);
      return ctr_word_t'((1 << (w - 1)) - 1);
   endfunction

   function automatic ctr_word_t ctr_top(int unsigned w);
      return ctr_word_t'((1 << w) - 1);
   endfunction

   // Saturating step toward the resolved direction
   function automatic ctr_word_t ctr_step(ctr_word_t c, logic taken, int unsigned w);
      if (taken)
         return (c == ctr_top(w)) ? c : c + ctr_word_t'(1);
      else
         return (c == '0) ? c : c - ctr_word_t'(1);
   endfunction

endpackage

// File: rtl/lhp_read_port.sv
module lhp_read_port #(
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned WORD_W  = 6,
   parameter int unsigned IDX_W   = 6
) (
   input  logic [ENTRIES*WORD_W-1:0] flat,
   input  logic [IDX_W-1:0]          idx,
   output logic [WORD_W-1:0]         q
);

   always_comb begin
      q = flat[int'(idx)*WORD_W +: WORD_W];
   end

endmodule

// File: rtl/lhp_hist_bank.sv
module lhp_hist_bank #(
   parameter int unsigned NUM_HREGS = 64,
   parameter int unsigned HIST_LEN  = 6,
   parameter int unsigned SEL_W     = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [SEL_W-1:0]              wr_sel,
   input  logic                          wr_bit,
   output logic [NUM_HREGS*HIST_LEN-1:0] hist_flat
);

   for (genvar g = 0; g < NUM_HREGS; g++) begin : g_reg
      logic [HIST_LEN-1:0] shreg;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            shreg <= '0;
         else if (wr_en && (wr_sel == SEL_W'(g)))
            shreg <= {shreg[HIST_LEN-2:0], wr_bit};
      end

      assign hist_flat[g*HIST_LEN +: HIST_LEN] = shreg;
   end

endmodule

// File: rtl/lhp_pht.sv
module lhp_pht #(
   parameter int unsigned HIST_LEN = 6,
   parameter int unsigned CTR_W    = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [HIST_LEN-1:0]                 wr_idx,
   input  logic                                wr_taken,
   output logic [(1 << HIST_LEN)*CTR_W-1:0]    ctr_flat
);
   import lhp_pkg::*;

   localparam int unsigned DEPTH = 1 << HIST_LEN;
   localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(ctr_weak_nt(CTR_W));

   for (genvar g = 0; g < DEPTH; g++) begin : g_ctr
      logic [CTR_W-1:0] ctr_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ctr_q <= CTR_INIT;
         else if (wr_en && (wr_idx == HIST_LEN'(g)))
            ctr_q <= CTR_W'(ctr_step(ctr_word_t'(ctr_q), wr_taken, CTR_W));
      end

      assign ctr_flat[g*CTR_W +: CTR_W] = ctr_q;
   end

endmodule

// File: rtl/local_hist_predictor.sv
module local_hist_predictor #(
   parameter int unsigned PC_W      = 32,
   parameter int unsigned PC_LSB    = 2,
   parameter int unsigned NUM_HREGS = 64,
   parameter int unsigned HIST_LEN  = 6,
   parameter int unsigned CTR_W     = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] pred_pc,
   output logic            pred_taken,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken
);

   localparam int unsigned SEL_W     = (NUM_HREGS > 1) ? $clog2(NUM_HREGS) : 1;
   localparam int unsigned PHT_DEPTH = 1 << HIST_LEN;

   // Elaboration-time parameter checks
   if (HIST_LEN < 2 || HIST_LEN > 12) begin : g_bad_hist
      $error("HIST_LEN must lie in 2..12");
   end
   if (CTR_W < 1 || CTR_W > lhp_pkg::CTR_W_MAX) begin : g_bad_ctr
      $error("CTR_W out of range");
   end
   if (NUM_HREGS > 1 && (1 << SEL_W) != NUM_HREGS) begin : g_bad_regs
      $error("NUM_HREGS must be a power of two");
   end
   if (PC_LSB + SEL_W > PC_W) begin : g_bad_pc
      $error("PC too narrow for register select");
   end

   logic [SEL_W-1:0]              pred_sel, upd_sel;
   logic [HIST_LEN-1:0]           pred_hist, upd_hist;
   logic [CTR_W-1:0]              pred_ctr;
   logic [NUM_HREGS*HIST_LEN-1:0] hist_flat;
   logic [PHT_DEPTH*CTR_W-1:0]    pht_flat;
   logic                          unused_bits;

   // Register select: a single register needs no PC bits at all
   if (NUM_HREGS == 1) begin : g_sel_single
      assign pred_sel = '0;
      assign upd_sel  = '0;
   end else begin : g_sel_pc
      assign pred_sel = pred_pc[PC_LSB +: SEL_W];
      assign upd_sel  = upd_pc[PC_LSB +: SEL_W];
   end

   lhp_hist_bank #(
      .NUM_HREGS(NUM_HREGS), .HIST_LEN(HIST_LEN), .SEL_W(SEL_W)
   ) u_hist (
      .clk(clk), .rst_n(rst_n),
      .wr_en(upd_valid), .wr_sel(upd_sel), .wr_bit(upd_taken),
      .hist_flat(hist_flat)
   );

   lhp_pht #(
      .HIST_LEN(HIST_LEN), .CTR_W(CTR_W)
   ) u_pht (
      .clk(clk), .rst_n(rst_n),
      .wr_en(upd_valid), .wr_idx(upd_hist), .wr_taken(upd_taken),
      .ctr_flat(pht_flat)
   );

   lhp_read_port #(
      .ENTRIES(NUM_HREGS), .WORD_W(HIST_LEN), .IDX_W(SEL_W)
   ) u_rd_pred_hist (
      .flat(hist_flat), .idx(pred_sel), .q(pred_hist)
   );

   lhp_read_port #(
      .ENTRIES(NUM_HREGS), .WORD_W(HIST_LEN), .IDX_W(SEL_W)
   ) u_rd_upd_hist (
      .flat(hist_flat), .idx(upd_sel), .q(upd_hist)
   );

   lhp_read_port #(
      .ENTRIES(PHT_DEPTH), .WORD_W(CTR_W), .IDX_W(HIST_LEN)
   ) u_rd_pred_ctr (
      .flat(pht_flat), .idx(pred_hist), .q(pred_ctr)
   );

   assign pred_taken  = pred_ctr[CTR_W-1];
   assign unused_bits = ^{pred_pc, upd_pc, pred_ctr};

endmodule

// File: rtl/lhp_checker.sv
module lhp_checker #(
   parameter int unsigned NUM_HREGS = 64,
   parameter int unsigned HIST_LEN  = 6,
   parameter int unsigned CTR_W     = 2,
   parameter int unsigned SEL_W     = 6
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               upd_valid,
   input logic                               upd_taken,
   input logic [SEL_W-1:0]                   upd_sel,
   input logic [HIST_LEN-1:0]                upd_hist,
   input logic [NUM_HREGS*HIST_LEN-1:0]      hist_flat,
   input logic [(1 << HIST_LEN)*CTR_W-1:0]   pht_flat
);

   localparam logic [CTR_W-1:0] CTR_MAX = '1;

   logic                lu_v, lu_t;
   logic [SEL_W-1:0]    lu_sel;
   logic [HIST_LEN-1:0] lu_hist;
   logic [CTR_W-1:0]    lu_ctr;
   logic [CTR_W-1:0]    now_ctr;
   logic [HIST_LEN-1:0] now_hist;

   // Record the last update and the state it started from
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lu_v    <= 1'b0;
         lu_t    <= 1'b0;
         lu_sel  <= '0;
         lu_hist <= '0;
         lu_ctr  <= '0;
      end else begin
         lu_v    <= upd_valid;
         lu_t    <= upd_taken;
         lu_sel  <= upd_sel;
         lu_hist <= upd_hist;
         lu_ctr  <= pht_flat[int'(upd_hist)*CTR_W +: CTR_W];
      end
   end

   always_comb begin
      now_ctr  = pht_flat[int'(lu_hist)*CTR_W +: CTR_W];
      now_hist = hist_flat[int'(lu_sel)*HIST_LEN +: HIST_LEN];
   end

   AST_CTR_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (lu_v && lu_t && lu_ctr != CTR_MAX) |-> (now_ctr == CTR_W'(lu_ctr + 1'b1))); // R4
   AST_CTR_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (lu_v && lu_t && lu_ctr == CTR_MAX) |-> (now_ctr == CTR_MAX)); // R4
   AST_CTR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (lu_v && !lu_t && lu_ctr != '0) |-> (now_ctr == CTR_W'(lu_ctr - 1'b1))); // R5
   AST_CTR_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (lu_v && !lu_t && lu_ctr == '0) |-> (now_ctr == '0)); // R5
   AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      lu_v |-> (now_hist == {lu_hist[HIST_LEN-2:0], lu_t})); // R6
   AST_STRONG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (lu_v && !lu_t && lu_ctr == CTR_MAX) |-> now_ctr[CTR_W-1]); // R7
   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !lu_v |-> ($stable(pht_flat) && $stable(hist_flat))); // R8

endmodule

bind local_hist_predictor lhp_checker #(
   .NUM_HREGS(NUM_HREGS), .HIST_LEN(HIST_LEN), .CTR_W(CTR_W), .SEL_W(SEL_W)
) u_lhp_chk (
   .clk(clk), .rst_n(rst_n),
   .upd_valid(upd_valid), .upd_taken(upd_taken),
   .upd_sel(upd_sel), .upd_hist(upd_hist),
   .hist_flat(hist_flat), .pht_flat(pht_flat)
);

// File: tb/local_hist_predictor_tb.sv
`timescale 1ns/1ps
module local_hist_predictor_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pred_pc = '0;
   logic        pred_taken;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_taken = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   local_hist_predictor u_dut (
      .clk(clk), .rst_n(rst_n),
      .pred_pc(pred_pc), .pred_taken(pred_taken),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
   );

   typedef struct packed {
      logic [31:0] pc;
      logic        v;
      logic        t;
      logic        e;
   } vec_t;

   // Hand-traced from reset: predicted direction is checked before the update applies
   localparam int NV = 12;
   localparam vec_t TBL [NV] = '{
      '{32'h0000_0104, 1'b1, 1'b1, 1'b0},  // A reg1 h0 c0=01; c0->10 h1=1
      '{32'h0000_0104, 1'b1, 1'b0, 1'b0},  // A h1=1 c1=01; c1->00 h1=2
      '{32'h0000_0108, 1'b1, 1'b1, 1'b1},  // B reg2 h0 c0=10 shared; c0->11
      '{32'h0000_0108, 1'b1, 1'b1, 1'b0},  // B h1 c1=00; c1->01 h2=3
      '{32'h0000_0507, 1'b1, 1'b1, 1'b0},  // alias of A: h1=2 c2=01; h1=5
      '{32'h0000_0108, 1'b1, 1'b0, 1'b0},  // B h3 c3=01; c3->00
      '{32'h0000_01FC, 1'b1, 1'b0, 1'b1},  // reg63 h0 c0=11; c0->10
      '{32'h0000_01FC, 1'b1, 1'b0, 1'b1},  // c0=10; c0->01
      '{32'h0000_01FC, 1'b0, 1'b1, 1'b0},  // c0=01; invalid update
      '{32'h0000_01FC, 1'b1, 1'b1, 1'b0},  // still 01; c0->10 h63=1
      '{32'h0000_0104, 1'b0, 1'b0, 1'b0},  // A h1=5 c5=01
      '{32'h0000_0100, 1'b1, 1'b1, 1'b1}   // reg0 h0 c0=10
   };
   localparam string TREQ [NV] = '{"R6", "R6", "R3", "R3", "R2", "R6",
                                   "R5", "R5", "R8", "R8", "R2", "R3"};

   task automatic chk(input string rq, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b", rq, what, act, exp);
      end
   endtask

   // Present pc on both sides, check prediction, let the next edge apply the update
   task automatic step(input logic [31:0] pc, input logic v, input logic t,
                       input logic exp, input string rq, input string what);
      @(negedge clk);
      pred_pc   = pc;
      upd_pc    = pc;
      upd_valid = v;
      upd_taken = t;
      #1;
      chk(rq, pred_taken, exp, what);
   endtask

   task automatic train(input logic [31:0] pc, input logic t);
      @(negedge clk);
      pred_pc   = pc;
      upd_pc    = pc;
      upd_valid = 1'b1;
      upd_taken = t;
   endtask

   task automatic idle();
      @(negedge clk);
      upd_valid = 1'b0;
      upd_taken = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      upd_valid = 1'b0;
      rst_n     = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_loop(input logic [31:0] pc, input int trip, input int iters,
                           input int check_from, input string what);
      for (int it = 0; it < iters; it++) begin
         for (int k = 0; k < trip; k++) begin
            logic t;
            t = (k != trip - 1);
            if (it >= check_from)
               step(pc, 1'b1, t, t, "R9", what);
            else
               train(pc, t);
         end
      end
      idle();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #400000;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      // R1: reset state, during and right after reset
      repeat (2) @(negedge clk);
      pred_pc = 32'h0000_0000; #1 chk("R1", pred_taken, 1'b0, "in reset pc0");
      pred_pc = 32'hFFFF_FFFC; #1 chk("R1", pred_taken, 1'b0, "in reset pc max");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      pred_pc = 32'h0000_0044; #1 chk("R1", pred_taken, 1'b0, "after reset pc44");
      pred_pc = 32'h1234_5678; #1 chk("R1", pred_taken, 1'b0, "after reset pc rnd");

      // Vector table: R2 R3 R5 R6 R8
      for (int i = 0; i < NV; i++)
         step(TBL[i].pc, TBL[i].v, TBL[i].t, TBL[i].e, TREQ[i], $sformatf("table step %0d", i));
      idle();

      // Saturation and hysteresis: R4 R7 R5
      do_reset();
      for (int i = 0; i < 6; i++) train(32'h0000_010C, 1'b1);         // reg3 pinned to 63
      step(32'h0000_010C, 1'b1, 1'b1, 1'b0, "R4", "c63 at 01");
      step(32'h0000_010C, 1'b1, 1'b1, 1'b1, "R4", "c63 at 10");
      step(32'h0000_010C, 1'b1, 1'b1, 1'b1, "R4", "c63 at 11");
      step(32'h0000_010C, 1'b1, 1'b0, 1'b1, "R4", "c63 held at 11");
      for (int i = 0; i < 6; i++) train(32'h0000_010C, 1'b1);         // back to 63
      step(32'h0000_010C, 1'b0, 1'b0, 1'b1, "R7", "strong taken after one not-taken");
      step(32'h0000_0110, 1'b1, 1'b0, 1'b1, "R5", "c0 at 10");
      step(32'h0000_0110, 1'b1, 1'b0, 1'b0, "R5", "c0 at 01");
      step(32'h0000_0110, 1'b1, 1'b0, 1'b0, "R5", "c0 at 00");
      step(32'h0000_0110, 1'b1, 1'b0, 1'b0, "R5", "c0 held at 00");
      step(32'h0000_0114, 1'b1, 1'b1, 1'b0, "R5", "c0 still 00 via reg5");
      step(32'h0000_0118, 1'b1, 1'b1, 1'b0, "R5", "c0 at 01 via reg6");
      step(32'h0000_011C, 1'b0, 1'b0, 1'b1, "R5", "c0 at 10 via reg7");
      idle();

      // R9: loop exits learned
      do_reset();
      run_loop(32'h0000_0230, 4, 12, 10, "loop trip 4");
      do_reset();
      run_loop(32'h0000_0230, 6, 12, 10, "loop trip 6");

      finish_run();
   end

endmodule